// File: doc/BRIEF.md
# Floating-Point Divide Special-Case Classifier

This block sits in front of the divide datapath of a double-extended floating-point unit. It looks at the dividend and the divisor before any quotient work starts. It sorts each operand into a class: zero, normal, denormal, infinity, quiet NaN, signalling NaN or unsupported encoding. From the two classes it decides four things: whether a fixed special result must replace the datapath output, what that result is, whether the destination register is written, and which of the invalid-operation (IE), zero-divide (ZE) and denormal-operand (DE) flags are raised.

The divisor can come from an 80-bit operand or from a 16- or 32-bit signed integer. An integer zero is taken as +0. The zero-divide mask and the invalid mask decide whether a faulting case writes a default value or suppresses the write. The classification logic is purely combinational. A single register stage presents its outputs one cycle after an accepted input.

Operand layout, both operands: bit 79 is the sign, bits 78:64 the biased exponent, bits 63:0 the significand, and bit 63 is the explicit integer bit. In a NaN, bit 62 is the quiet bit.

Top module: `fdsc_top`

## Requirements
- R1: An input presented with `in_valid` high produces `out_valid` high on the next cycle, with all outputs reflecting that input. `out_valid` is low in every other cycle. Reset clears every output to zero.
- R2: Infinity divided by infinity and zero divided by zero raise IE with override set. If the invalid mask is 1, the result is the default NaN FFFF_C000000000000000 (hex) and it is written. If the mask is 0, `wr_en` is 0.
- R3: A signalling NaN or an unsupported encoding on either operand raises IE, handled as in R2. A signalling NaN has exponent all ones, bit 63 set, bit 62 clear and a nonzero remainder. An unsupported encoding has a nonzero exponent with bit 63 clear. This rule takes priority over quiet-NaN propagation.
- R4: A finite nonzero dividend divided by zero raises ZE with override set. If the zero-divide mask is 1, the result is an infinity (exponent all ones, significand 8000000000000000 hex) whose sign is the XOR of the operand signs, and it is written. If the mask is 0, `wr_en` is 0.
- R5: A zero dividend over a finite nonzero divisor gives an overridden zero whose sign is the XOR of the operand signs, with no flag raised.
- R6: A finite dividend (zero included) over an infinite divisor gives a signed zero. An infinite dividend over a finite divisor (zero included) gives a signed infinity. Neither case raises a flag, and the sign is the XOR of the operand signs.
- R7: A quiet NaN operand is returned unchanged as the result, written, with no flag raised. When both operands are quiet NaNs, the one with the larger 64-bit significand wins. On a tie, the dividend wins.
- R8: A denormal operand (exponent zero, significand nonzero) raises DE, except when IE is raised or a NaN is propagated. DE can coincide with ZE.
- R9: When `int_src` is 1, the divisor port is ignored and the divisor is the integer on `int_data`. It is all 32 bits when `int_is32` is 1, otherwise bits 15:0. Its most significant bit is the sign, and a value of 0 is +0.
- R10: When no special case applies, override is 0, the result is zero, `wr_en` is 1, and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| dividend | input | 80 | Dividend, double-extended |
| divisor | input | 80 | Divisor, double-extended (used when int_src is 0) |
| int_src | input | 1 | Divisor comes from int_data |
| int_is32 | input | 1 | Integer divisor is 32 bits, else 16 |
| int_data | input | 32 | Integer divisor value |
| zm_mask | input | 1 | Zero-divide mask |
| im_mask | input | 1 | Invalid-operation mask |
| out_valid | output | 1 | Outputs valid this cycle |
| override | output | 1 | Special result replaces datapath result |
| result | output | 80 | Special result value |
| wr_en | output | 1 | Destination write enable |
| exc_ie | output | 1 | Invalid-operation flag |
| exc_ze | output | 1 | Zero-divide flag |
| exc_de | output | 1 | Denormal-operand flag |

## Verification
The block holds no state beyond one output register. A wrong classification or a wrong priority therefore shows on the outputs in the cycle right after the offending operands, as a wrong flag, a wrong `wr_en` or a wrong special value. The directed cases are chosen so that each pair of neighbouring priority rules gets an input on which they disagree: signalling NaN against quiet NaN, infinity over zero against finite over zero, and an integer zero against a NaN placed on the ignored divisor port. A swapped branch or a misread mask then changes at least one port bit.

// File: rtl/fdsc_pkg.sv
package fdsc_pkg;

   // operand classes
   typedef enum logic [2:0] {
      CL_ZERO,
      CL_NORM,
      CL_DENORM,
      CL_INF,
      CL_QNAN,
      CL_SNAN,
      CL_UNSUP
   } fp_class_e;

   typedef struct packed {
      logic      sign;
      fp_class_e cls;
   } op_info_t;

   // special result selection
   typedef enum logic [2:0] {
      SP_NONE,
      SP_DEFNAN,
      SP_PROP_A,
      SP_PROP_B,
      SP_INF,
      SP_ZERO
   } spec_sel_e;

endpackage

// File: rtl/fdsc_opclass.sv
module fdsc_opclass
   import fdsc_pkg::*;
#(
   parameter int EXP_W = 15,
   parameter int MAN_W = 64,
   localparam int FP_W = 1 + EXP_W + MAN_W
) (
   input  logic [FP_W-1:0] op,
   output op_info_t        info
);

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_ones;
   logic             exp_zero;
   logic             int_bit;
   logic             quiet_bit;
   logic             frac_nz;
   logic             man_nz;

   assign exp_f     = op[FP_W-2:MAN_W];
   assign man_f     = op[MAN_W-1:0];
   assign exp_ones  = &exp_f;
   assign exp_zero  = ~|exp_f;
   assign int_bit   = man_f[MAN_W-1];
   assign quiet_bit = man_f[MAN_W-2];
   assign frac_nz   = |man_f[MAN_W-2:0];
   assign man_nz    = |man_f;

   always_comb begin
      info.sign = op[FP_W-1];
      if (exp_zero) begin
         info.cls = man_nz ? CL_DENORM : CL_ZERO;
      end else if (exp_ones) begin
         if (!int_bit)       info.cls = CL_UNSUP;
         else if (!frac_nz)  info.cls = CL_INF;
         else if (quiet_bit) info.cls = CL_QNAN;
         else                info.cls = CL_SNAN;
      end else begin
         info.cls = int_bit ? CL_NORM : CL_UNSUP;
      end
   end

endmodule

// File: rtl/fdsc_intsrc.sv
module fdsc_intsrc
   import fdsc_pkg::*;
#(
   parameter int INT_W = 32,
   localparam int NARROW_W = 16
) (
   input  logic             int_is32,
   input  logic [INT_W-1:0] int_data,
   output op_info_t         info
);

   logic is_zero;
   logic is_neg;

   generate
      if (INT_W > NARROW_W) begin : g_wide
         logic [NARROW_W-1:0] narrow;
         assign narrow  = int_data[NARROW_W-1:0];
         assign is_zero = int_is32 ? ~|int_data : ~|narrow;
         assign is_neg  = int_is32 ? int_data[INT_W-1] : narrow[NARROW_W-1];
      end else begin : g_narrow
         logic unused_sel;
         assign unused_sel = int_is32;
         assign is_zero    = ~|int_data;
         assign is_neg     = int_data[INT_W-1];
      end
   endgenerate

   // integer zero is always +0
   always_comb begin
      info.sign = is_zero ? 1'b0 : is_neg;
      info.cls  = is_zero ? CL_ZERO : CL_NORM;
   end

endmodule

// File: rtl/fdsc_decide.sv
module fdsc_decide
   import fdsc_pkg::*;
#(
   parameter int MAN_W = 64
) (
   input  op_info_t         a_info,
   input  op_info_t         b_info,
   input  logic [MAN_W-1:0] a_man,
   input  logic [MAN_W-1:0] b_man,
   input  logic             zm_mask,
   input  logic             im_mask,
   output spec_sel_e        sel,
   output logic             res_sign,
   output logic             ie,
   output logic             ze,
   output logic             de,
   output logic             wr_en
);

   logic a_sig, b_sig, a_q, b_q;
   logic a_zero, b_zero, a_inf, b_inf;
   logic a_fnz, any_den, invalid;

   assign a_sig   = (a_info.cls == CL_SNAN) || (a_info.cls == CL_UNSUP);
   assign b_sig   = (b_info.cls == CL_SNAN) || (b_info.cls == CL_UNSUP);
   assign a_q     = (a_info.cls == CL_QNAN);
   assign b_q     = (b_info.cls == CL_QNAN);
   assign a_zero  = (a_info.cls == CL_ZERO);
   assign b_zero  = (b_info.cls == CL_ZERO);
   assign a_inf   = (a_info.cls == CL_INF);
   assign b_inf   = (b_info.cls == CL_INF);
   assign a_fnz   = (a_info.cls == CL_NORM) || (a_info.cls == CL_DENORM);
   assign any_den = (a_info.cls == CL_DENORM) || (b_info.cls == CL_DENORM);
   assign invalid = a_sig || b_sig || (a_inf && b_inf) || (a_zero && b_zero);

   assign res_sign = a_info.sign ^ b_info.sign;

   always_comb begin
      sel = SP_NONE;
      ie  = 1'b0;
      ze  = 1'b0;
      if (invalid) begin
         sel = SP_DEFNAN;
         ie  = 1'b1;
      end else if (a_q && b_q) begin
         sel = (b_man > a_man) ? SP_PROP_B : SP_PROP_A;
      end else if (a_q) begin
         sel = SP_PROP_A;
      end else if (b_q) begin
         sel = SP_PROP_B;
      end else if (a_fnz && b_zero) begin
         sel = SP_INF;
         ze  = 1'b1;
      end else if (a_inf) begin
         sel = SP_INF;
      end else if (b_inf || a_zero) begin
         sel = SP_ZERO;
      end
   end

   assign de    = any_den && !invalid && !a_q && !b_q;
   assign wr_en = ie ? im_mask : (ze ? zm_mask : 1'b1);

endmodule

// File: rtl/fdsc_resmux.sv
module fdsc_resmux
   import fdsc_pkg::*;
#(
   parameter int EXP_W = 15,
   parameter int MAN_W = 64,
   localparam int FP_W = 1 + EXP_W + MAN_W
) (
   input  spec_sel_e       sel,
   input  logic            res_sign,
   input  logic [FP_W-1:0] a_op,
   input  logic [FP_W-1:0] b_op,
   output logic [FP_W-1:0] result
);

   localparam logic [EXP_W-1:0] EXP_MAX   = '1;
   localparam logic [MAN_W-1:0] MAN_INF   = {1'b1, {(MAN_W-1){1'b0}}};
   localparam logic [MAN_W-1:0] MAN_QNAN  = {2'b11, {(MAN_W-2){1'b0}}};
   localparam logic [FP_W-1:0]  VAL_DNAN  = {1'b1, EXP_MAX, MAN_QNAN};

   always_comb begin
      unique case (sel)
         SP_DEFNAN: result = VAL_DNAN;
         SP_PROP_A: result = a_op;
         SP_PROP_B: result = b_op;
         SP_INF:    result = {res_sign, EXP_MAX, MAN_INF};
         SP_ZERO:   result = {res_sign, {(FP_W-1){1'b0}}};
         default:   result = '0;
      endcase
   end

endmodule

// File: rtl/fdsc_top.sv
module fdsc_top
   import fdsc_pkg::*;
#(
   parameter int EXP_W = 15,
   parameter int MAN_W = 64,
   parameter int INT_W = 32,
   localparam int FP_W = 1 + EXP_W + MAN_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [FP_W-1:0] dividend,
   input  logic [FP_W-1:0] divisor,
   input  logic            int_src,
   input  logic            int_is32,
   input  logic [INT_W-1:0] int_data,
   input  logic            zm_mask,
   input  logic            im_mask,
   output logic            out_valid,
   output logic            override,
   output logic [FP_W-1:0] result,
   output logic            wr_en,
   output logic            exc_ie,
   output logic            exc_ze,
   output logic            exc_de
);

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fdsc_top: EXP_W must be at least 2");
      end
      if (MAN_W < 3) begin : g_bad_man
         $error("fdsc_top: MAN_W must be at least 3");
      end
      if (INT_W < 16) begin : g_bad_int
         $error("fdsc_top: INT_W must be at least 16");
      end
   endgenerate

   op_info_t  a_info, b_flt_info, b_int_info, b_info;
   spec_sel_e sel;
   logic      res_sign, ie_c, ze_c, de_c, wr_c;
   logic [FP_W-1:0] res_c;

   fdsc_opclass #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
      .op   (dividend),
      .info (a_info)
   );

   fdsc_opclass #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
      .op   (divisor),
      .info (b_flt_info)
   );

   fdsc_intsrc #(.INT_W(INT_W)) u_int (
      .int_is32 (int_is32),
      .int_data (int_data),
      .info     (b_int_info)
   );

   assign b_info = int_src ? b_int_info : b_flt_info;

   fdsc_decide #(.MAN_W(MAN_W)) u_dec (
      .a_info   (a_info),
      .b_info   (b_info),
      .a_man    (dividend[MAN_W-1:0]),
      .b_man    (divisor[MAN_W-1:0]),
      .zm_mask  (zm_mask),
      .im_mask  (im_mask),
      .sel      (sel),
      .res_sign (res_sign),
      .ie       (ie_c),
      .ze       (ze_c),
      .de       (de_c),
      .wr_en    (wr_c)
   );

   fdsc_resmux #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mux (
      .sel      (sel),
      .res_sign (res_sign),
      .a_op     (dividend),
      .b_op     (divisor),
      .result   (res_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         override  <= 1'b0;
         result    <= '0;
         wr_en     <= 1'b0;
         exc_ie    <= 1'b0;
         exc_ze    <= 1'b0;
         exc_de    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            override <= (sel != SP_NONE);
            result   <= res_c;
            wr_en    <= wr_c;
            exc_ie   <= ie_c;
            exc_ze   <= ze_c;
            exc_de   <= de_c;
         end
      end
   end

endmodule

// File: rtl/fdsc_chk.sv
module fdsc_chk #(
   parameter int EXP_W = 15,
   parameter int MAN_W = 64,
   localparam int FP_W = 1 + EXP_W + MAN_W
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            zm_mask,
   input logic            im_mask,
   input logic            out_valid,
   input logic            override,
   input logic [FP_W-1:0] result,
   input logic            wr_en,
   input logic            exc_ie,
   input logic            exc_ze
);

   localparam logic [FP_W-1:0] DNAN = {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};
   localparam logic [FP_W-2:0] INF_MAG = {{EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   assert_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_ie_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && exc_ie) |-> (override && (wr_en == $past(im_mask))));

   assert_ie_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && exc_ie && wr_en) |-> (result == DNAN));

   assert_ze_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && exc_ze) |-> (!exc_ie && override && (wr_en == $past(zm_mask))));

   assert_ze_inf_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && exc_ze && wr_en) |-> (result[FP_W-2:0] == INF_MAG));

   assert_plain_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !override) |-> (wr_en && !exc_ie && !exc_ze && (result == '0)));

endmodule

bind fdsc_top fdsc_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .zm_mask   (zm_mask),
   .im_mask   (im_mask),
   .out_valid (out_valid),
   .override  (override),
   .result    (result),
   .wr_en     (wr_en),
   .exc_ie    (exc_ie),
   .exc_ze    (exc_ze)
);

// File: tb/fdsc_top_tb.sv
module fdsc_top_tb;

   localparam int CLK_PERIOD = 10;

   localparam logic [79:0] P_ONE  = 80'h3FFF_8000_0000_0000_0000;
   localparam logic [79:0] N_TWO  = 80'hC000_8000_0000_0000_0000;
   localparam logic [79:0] P_ZERO = 80'h0;
   localparam logic [79:0] N_ZERO = 80'h8000_0000_0000_0000_0000;
   localparam logic [79:0] P_INF  = 80'h7FFF_8000_0000_0000_0000;
   localparam logic [79:0] N_INF  = 80'hFFFF_8000_0000_0000_0000;
   localparam logic [79:0] DNAN   = 80'hFFFF_C000_0000_0000_0000;
   localparam logic [79:0] QA     = 80'h7FFF_C000_0000_0000_1234;
   localparam logic [79:0] QB     = 80'hFFFF_C000_0000_0000_5678;
   localparam logic [79:0] QC     = 80'hFFFF_C000_0000_0000_1234;
   localparam logic [79:0] SNAN   = 80'h7FFF_8000_0000_0000_0001;
   localparam logic [79:0] UNSUP  = 80'h3FFF_4000_0000_0000_0000;
   localparam logic [79:0] DEN    = 80'h0000_0000_0000_0000_0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [79:0] dividend = '0;
   logic [79:0] divisor = '0;
   logic        int_src = 1'b0;
   logic        int_is32 = 1'b0;
   logic [31:0] int_data = '0;
   logic        zm_mask = 1'b0;
   logic        im_mask = 1'b0;
   logic        out_valid, override, wr_en, exc_ie, exc_ze, exc_de;
   logic [79:0] result;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fdsc_top u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .dividend(dividend), .divisor(divisor),
      .int_src(int_src), .int_is32(int_is32), .int_data(int_data),
      .zm_mask(zm_mask), .im_mask(im_mask),
      .out_valid(out_valid), .override(override), .result(result),
      .wr_en(wr_en), .exc_ie(exc_ie), .exc_ze(exc_ze), .exc_de(exc_de)
   );

   task automatic expect_out(input string req, input logic ev, input logic eo,
                             input logic [79:0] er, input logic ew,
                             input logic ei, input logic ez, input logic ed);
      n_vec++;
      if ({out_valid, override, result, wr_en, exc_ie, exc_ze, exc_de} !==
          {ev, eo, er, ew, ei, ez, ed}) begin
         n_bad++;
         $display("FAIL %s: got v=%b ov=%b res=%h wr=%b ie=%b ze=%b de=%b, exp v=%b ov=%b res=%h wr=%b ie=%b ze=%b de=%b",
                  req, out_valid, override, result, wr_en, exc_ie, exc_ze, exc_de,
                  ev, eo, er, ew, ei, ez, ed);
      end
   endtask

   // drive one operand pair, sample the registered outputs a cycle later
   task automatic apply(input logic [79:0] a, input logic [79:0] b,
                        input logic isrc, input logic i32, input logic [31:0] idat,
                        input logic zm, input logic im);
      @(negedge clk);
      dividend = a; divisor = b; int_src = isrc; int_is32 = i32;
      int_data = idat; zm_mask = zm; im_mask = im; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      expect_out("R1 reset", 0, 0, '0, 0, 0, 0, 0);
   endtask

   task automatic t_plain();
      apply(P_ONE, N_TWO, 0, 0, 0, 0, 0);
      expect_out("R10 normal", 1, 0, '0, 1, 0, 0, 0);
      @(negedge clk);
      expect_out("R1 idle", 0, 0, '0, 1, 0, 0, 0);
   endtask

   task automatic t_invalid();
      apply(P_INF, N_INF, 0, 0, 0, 0, 1);
      expect_out("R2 inf/inf masked", 1, 1, DNAN, 1, 1, 0, 0);
      apply(P_INF, P_INF, 0, 0, 0, 1, 0);
      expect_out("R2 inf/inf unmasked", 1, 1, DNAN, 0, 1, 0, 0);
      apply(N_ZERO, P_ZERO, 0, 0, 0, 1, 1);
      expect_out("R2 0/0", 1, 1, DNAN, 1, 1, 0, 0);
   endtask

   task automatic t_signal();
      apply(SNAN, P_ONE, 0, 0, 0, 0, 1);
      expect_out("R3 snan", 1, 1, DNAN, 1, 1, 0, 0);
      apply(P_ONE, UNSUP, 0, 0, 0, 1, 0);
      expect_out("R3 unsupported", 1, 1, DNAN, 0, 1, 0, 0);
      apply(QA, SNAN, 0, 0, 0, 0, 1);
      expect_out("R3 snan over qnan", 1, 1, DNAN, 1, 1, 0, 0);
      apply(SNAN, DEN, 0, 0, 0, 0, 1);
      expect_out("R8 no DE with IE", 1, 1, DNAN, 1, 1, 0, 0);
   endtask

   task automatic t_zdiv();
      apply(P_ONE, P_ZERO, 0, 0, 0, 1, 0);
      expect_out("R4 +1/+0", 1, 1, P_INF, 1, 0, 1, 0);
      apply(N_TWO, P_ZERO, 0, 0, 0, 1, 0);
      expect_out("R4 -2/+0", 1, 1, N_INF, 1, 0, 1, 0);
      apply(P_ONE, N_ZERO, 0, 0, 0, 1, 0);
      expect_out("R4 +1/-0", 1, 1, N_INF, 1, 0, 1, 0);
      apply(P_ONE, P_ZERO, 0, 0, 0, 0, 1);
      expect_out("R4 unmasked", 1, 1, P_INF, 0, 0, 1, 0);
   endtask

   task automatic t_signs();
      apply(P_ZERO, N_TWO, 0, 0, 0, 0, 0);
      expect_out("R5 +0/-2", 1, 1, N_ZERO, 1, 0, 0, 0);
      apply(N_ZERO, N_TWO, 0, 0, 0, 0, 0);
      expect_out("R5 -0/-2", 1, 1, P_ZERO, 1, 0, 0, 0);
   endtask

   task automatic t_inf();
      apply(P_ONE, N_INF, 0, 0, 0, 0, 0);
      expect_out("R6 1/-inf", 1, 1, N_ZERO, 1, 0, 0, 0);
      apply(N_INF, P_ONE, 0, 0, 0, 0, 0);
      expect_out("R6 -inf/1", 1, 1, N_INF, 1, 0, 0, 0);
      apply(P_INF, N_ZERO, 0, 0, 0, 0, 0);
      expect_out("R6 inf/-0", 1, 1, N_INF, 1, 0, 0, 0);
   endtask

   task automatic t_qnan();
      apply(QA, P_ONE, 0, 0, 0, 0, 0);
      expect_out("R7 qnan dividend", 1, 1, QA, 1, 0, 0, 0);
      apply(P_ONE, QB, 0, 0, 0, 0, 0);
      expect_out("R7 qnan divisor", 1, 1, QB, 1, 0, 0, 0);
      apply(QA, QB, 0, 0, 0, 0, 0);
      expect_out("R7 larger divisor", 1, 1, QB, 1, 0, 0, 0);
      apply(QB, QA, 0, 0, 0, 0, 0);
      expect_out("R7 larger dividend", 1, 1, QB, 1, 0, 0, 0);
      apply(QC, QA, 0, 0, 0, 0, 0);
      expect_out("R7 tie", 1, 1, QC, 1, 0, 0, 0);
      apply(QA, DEN, 0, 0, 0, 0, 0);
      expect_out("R8 no DE with NaN", 1, 1, QA, 1, 0, 0, 0);
   endtask

   task automatic t_denorm();
      apply(DEN, P_ONE, 0, 0, 0, 0, 0);
      expect_out("R8 denormal", 1, 0, '0, 1, 0, 0, 1);
      apply(DEN, P_ZERO, 0, 0, 0, 1, 0);
      expect_out("R8 denormal with ZE", 1, 1, P_INF, 1, 0, 1, 1);
   endtask

   task automatic t_int();
      apply(P_ONE, QB, 1, 0, 32'h0001_0000, 1, 0);
      expect_out("R9 int16 zero", 1, 1, P_INF, 1, 0, 1, 0);
      apply(P_ONE, QB, 1, 1, 32'h0001_0000, 1, 0);
      expect_out("R9 int32 nonzero", 1, 0, '0, 1, 0, 0, 0);
      apply(P_ZERO, P_ONE, 1, 0, 32'h0000_8000, 0, 0);
      expect_out("R9 int16 negative", 1, 1, N_ZERO, 1, 0, 0, 0);
      apply(P_INF, P_ONE, 1, 1, 32'h8000_0000, 0, 0);
      expect_out("R9 int32 negative", 1, 1, N_INF, 1, 0, 0, 0);
      apply(N_TWO, N_ZERO, 1, 1, 32'h0, 1, 0);
      expect_out("R9 int zero is +0", 1, 1, N_INF, 1, 0, 1, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 2 + 1);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_plain();
      t_invalid();
      t_signal();
      t_zdiv();
      t_signs();
      t_inf();
      t_qnan();
      t_denorm();
      t_int();
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule